// File: doc/BRIEF.md
# SMBus Bus-Abuse Timeout Monitor

This block watches the synchronized clock and data lines of an SMBus slave port. From them it raises a one-cycle reset request for the slave's protocol state machine when the host breaks the bus timing rules. It finds Start and Stop conditions on its own. While a transaction is open, it adds up every tick during which the clock line sits low, across all low phases. When that total reaches a limit, it asks for a reset. A second, independent timer measures how long the clock line has stayed high without a break, and fires when that reaches its own limit.

Time is measured in ticks of a prescaled enable, typically one per millisecond, so both limits are parameters in tick units. With a 1 ms tick the defaults give 25 ms of total low time and 50 ms of continuous high time. The lines must already be synchronized to `clk_i`. Chip-level reset is handled elsewhere. The output is a control pulse with no handshake, so no back-pressure applies.

Top module: `smbus_timeout_mon`

## Requirements
- R1: After reset, `slave_rst_o` is 0, both timers are empty, no transaction is open, and the high timer is armed.
- R2: A Start is SDA going 1 to 0 while SCL is 1 in both the previous and the current sample. A Stop is SDA going 0 to 1 under the same SCL condition. An SDA fall while SCL is 0 opens no transaction.
- R3: While a transaction is open, every tick with SCL at 0 adds one to the low total, whether or not SCL went high in between. The tick that brings the total to LOW_LIM_TICKS makes `slave_rst_o` 1 on the next clock.
- R4: Ticks with SCL at 0 outside a transaction (before a Start, after a Stop) add nothing.
- R5: A Stop before the low total reaches its limit clears the total and produces no reset.
- R6: A repeated Start inside a transaction clears the low total and keeps the transaction open.
- R7: Each tick with SCL at 1 adds one to the high timer. Any sample with SCL at 0 clears it. The tick that brings it to HIGH_LIM_TICKS makes `slave_rst_o` 1 on the next clock.
- R8: Every reset pulse lasts exactly one clock. After a low-total reset, the transaction is closed, and nothing accumulates again until a new Start. After a high-time reset, the high timer stays empty until SCL has been seen at 0.
- R9: Clock cycles with `tick_i` at 0 advance neither timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base enable, one cycle per tick |
| scl_i | input | 1 | Synchronized SMBus clock line |
| sda_i | input | 1 | Synchronized SMBus data line |
| slave_rst_o | output | 1 | One-cycle reset request to the slave state machine |

## Verification
The bench builds the low limit out of several short low phases separated by high phases. A design that timed only one continuous low stretch would never fire there. Other cases place a Stop one tick short of the limit, a repeated Start in the middle of a transaction, and a long run of low ticks outside any transaction. Each of these must yield no pulse, so a design that missed a clear or counted outside a transaction would issue a false reset. A held-high bus is kept well past its limit to catch a design that fires again and again on an idle bus. SDA falling under a low SCL catches a too-loose Start detector. Clock-only cycles with no tick catch a timer that counts clock cycles instead of ticks. Random traffic against a cycle-exact bench model checks that each pulse appears on the right clock.

// File: rtl/smbto_pkg.sv
`timescale 1ns/1ps
package smbto_pkg;
  typedef struct packed {
    logic start;
    logic stop;
  } bus_evt_t;

  function automatic int cnt_bits(input int lim);
    return $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/smbto_cond_det.sv
`timescale 1ns/1ps
module smbto_cond_det
  import smbto_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o
);
  logic scl_q, sda_q;

  // idle bus is high on both lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    evt_o.start = scl_i & scl_q &  sda_q & ~sda_i;
    evt_o.stop  = scl_i & scl_q & ~sda_q &  sda_i;
  end

  // R2: the two conditions exclude each other
  p_evt_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_o.start && evt_o.stop));
endmodule

// File: rtl/smbto_low_acc.sv
`timescale 1ns/1ps
module smbto_low_acc
  import smbto_pkg::*;
#(
  parameter int LIM = 25
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     scl_i,
  input  bus_evt_t evt_i,
  output logic     fire_o
);
  localparam int            W    = cnt_bits(LIM);
  localparam logic [W-1:0] LAST = W'(LIM - 1);

  logic         in_xfer;
  logic [W-1:0] low_cnt;
  logic         acc_en;

  assign acc_en = in_xfer & tick_i & ~scl_i;
  assign fire_o = acc_en & (low_cnt == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_xfer <= 1'b0;
      low_cnt <= '0;
    end else begin
      if (fire_o || evt_i.stop)  in_xfer <= 1'b0;
      else if (evt_i.start)      in_xfer <= 1'b1;

      if (evt_i.start || evt_i.stop || fire_o) low_cnt <= '0;
      else if (acc_en)                         low_cnt <= low_cnt + 1'b1;
    end
  end

  // R4: no low time is held while no transaction is open
  p_idle_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_xfer |-> (low_cnt == '0));
  // R3: the total never passes the last value below the limit
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_cnt <= LAST);
  // R8: a low-total reset closes the transaction
  p_fire_closes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !in_xfer);
endmodule

// File: rtl/smbto_high_tmr.sv
`timescale 1ns/1ps
module smbto_high_tmr
  import smbto_pkg::*;
#(
  parameter int LIM = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic scl_i,
  output logic fire_o
);
  localparam int            W    = cnt_bits(LIM);
  localparam logic [W-1:0] LAST = W'(LIM - 1);

  logic         armed;
  logic [W-1:0] hi_cnt;
  logic         cnt_en;

  assign cnt_en = armed & tick_i & scl_i;
  assign fire_o = cnt_en & (hi_cnt == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed  <= 1'b1;
      hi_cnt <= '0;
    end else begin
      if (fire_o)      armed <= 1'b0;
      else if (!scl_i) armed <= 1'b1;

      if (!scl_i || fire_o) hi_cnt <= '0;
      else if (cnt_en)      hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R7: the high timer never passes the last value below the limit
  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_cnt <= LAST);
  // R8: no second high-time reset without SCL going low in between
  p_no_refire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && scl_i) |=> !fire_o);
endmodule

// File: rtl/smbus_timeout_mon.sv
`timescale 1ns/1ps
module smbus_timeout_mon
  import smbto_pkg::*;
#(
  parameter int LOW_LIM_TICKS  = 25,
  parameter int HIGH_LIM_TICKS = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic slave_rst_o
);
  bus_evt_t evt;
  logic     fire_low, fire_high;

  smbto_cond_det u_cond (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt_o (evt)
  );

  smbto_low_acc #(.LIM(LOW_LIM_TICKS)) u_low (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .scl_i (scl_i),
    .evt_i (evt),
    .fire_o(fire_low)
  );

  smbto_high_tmr #(.LIM(HIGH_LIM_TICKS)) u_high (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .scl_i (scl_i),
    .fire_o(fire_high)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slave_rst_o <= 1'b0;
    else         slave_rst_o <= fire_low | fire_high;
  end

  // R8: the request lasts one clock
  p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_rst_o |=> !slave_rst_o);
  // R3: a low-total reset only comes from a tick with SCL low
  p_low_fire_scl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_low |-> (!scl_i && tick_i));
  // R9: nothing fires on a cycle without a tick
  p_tick_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !slave_rst_o);
endmodule

// File: tb/smbus_timeout_mon_tb_top.sv
`timescale 1ns/1ps
module smbus_timeout_mon_tb_top;
  localparam int LOWL = 12;
  localparam int HIGHL = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, scl = 1'b1, sda = 1'b1;
  logic slave_rst;

  int vecs = 0, fails = 0, pulses = 0;

  // bench model state
  bit m_scl = 1, m_sda = 1, m_xfer = 0, m_arm = 1, m_out = 0;
  int m_lc = 0, m_hc = 0;

  always #4 clk = ~clk;

  smbus_timeout_mon #(.LOW_LIM_TICKS(LOWL), .HIGH_LIM_TICKS(HIGHL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .scl_i(scl), .sda_i(sda), .slave_rst_o(slave_rst)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: act=running exp=finished");
    summary();
    $finish;
  end

  // one clock: compare, drive, then advance the model past the next edge
  task automatic step(input bit s, input bit d, input bit t);
    bit st, sp, fl, fh;
    @(negedge clk);
    vecs++;
    if (slave_rst !== m_out) begin
      fails++;
      $display("FAIL R8 pulse timing: act=%b exp=%b at %0t", slave_rst, m_out, $time);
    end
    if (slave_rst === 1'b1) pulses++;
    scl = s; sda = d; tick = t;
    st = s & m_scl & m_sda & ~d;
    sp = s & m_scl & ~m_sda & d;
    fl = m_xfer & t & ~s & (m_lc == LOWL - 1);
    fh = m_arm & t & s & (m_hc == HIGHL - 1);
    m_out = fl | fh;
    if (st || sp || fl) m_lc = 0;
    else if (m_xfer && t && !s) m_lc++;
    if (fl || sp) m_xfer = 0;
    else if (st) m_xfer = 1;
    if (!s || fh) m_hc = 0;
    else if (m_arm && t && s) m_hc++;
    if (fh) m_arm = 0;
    else if (!s) m_arm = 1;
    m_scl = s; m_sda = d;
  endtask

  task automatic put(input bit s, input bit d, input bit t, input int n);
    for (int i = 0; i < n; i++) step(s, d, t);
  endtask

  task automatic chk(input string req, input int got, input int exp);
    vecs++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic rest();  put(0, 1, 0, 1); put(1, 1, 0, 1); endtask
  task automatic do_start(); put(1, 1, 0, 1); put(1, 0, 0, 1); put(0, 0, 0, 1); endtask
  task automatic do_stop();  put(0, 0, 0, 1); put(1, 0, 0, 1); put(1, 1, 0, 1); endtask
  task automatic flush();    put(scl, sda, 0, 2); endtask

  initial begin
    int p0;
    bit s, d, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 output after reset", int'(slave_rst), 0);

    // R3: limit reached in pieces; R8: no more after it fires
    rest(); p0 = pulses;
    do_start();
    put(0, 0, 1, 5); put(1, 0, 1, 3);
    put(0, 0, 1, 5); put(1, 0, 1, 3);
    put(0, 0, 1, 2);
    flush();
    chk("R3 cumulative low reset", pulses - p0, 1);
    put(0, 0, 1, 10); do_stop(); flush();
    chk("R8 no refire after low reset", pulses - p0, 1);

    // R4 and R5
    rest(); p0 = pulses;
    put(0, 1, 1, 20);
    do_start(); put(0, 0, 1, 11); do_stop();
    put(0, 1, 1, 20); flush();
    chk("R5 stop before limit / R4 idle low", pulses - p0, 0);

    // R6: repeated start clears the total
    rest(); p0 = pulses;
    do_start(); put(0, 0, 1, 8);
    put(0, 1, 0, 1); put(1, 1, 0, 1); put(1, 0, 0, 1); put(0, 0, 0, 1);
    put(0, 0, 1, 8); do_stop(); flush();
    chk("R6 repeated start clears", pulses - p0, 0);

    // R2: SDA falling under low SCL is no Start
    rest(); p0 = pulses;
    put(0, 1, 0, 1); put(0, 0, 0, 1); put(0, 0, 1, 20);
    put(0, 1, 0, 1); put(1, 1, 0, 1); flush();
    chk("R2 no start with SCL low", pulses - p0, 0);

    // R7 then R8 on continuous high
    rest(); p0 = pulses;
    put(0, 1, 0, 1); put(1, 1, 1, HIGHL); flush();
    chk("R7 continuous high reset", pulses - p0, 1);
    put(1, 1, 1, 40); flush();
    chk("R8 no refire while high", pulses - p0, 1);
    put(0, 1, 0, 1); put(1, 1, 1, 15); put(0, 1, 0, 1); put(1, 1, 1, 15);
    put(0, 1, 0, 2);
    chk("R7 low sample clears high timer", pulses - p0, 1);

    // R9: clocks without ticks
    rest(); p0 = pulses;
    do_start(); put(0, 0, 0, 100); do_stop(); put(0, 1, 0, 1); flush();
    chk("R9 no tick no count", pulses - p0, 0);

    // random traffic against the model
    void'($urandom(32'h1c3d_5a7b));
    s = scl; d = sda;
    p0 = pulses;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 4 == 0) s = ~s;
      if ($urandom % 6 == 0) d = ~d;
      t = ($urandom % 2) == 0;
      step(s, d, t);
    end
    flush();
    if (pulses == p0) begin
      fails++;
      $display("FAIL R3/R7 random run: act=%0d exp=>0 pulses", pulses - p0);
    end

    summary();
    $finish;
  end
endmodule